// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block models a synchronous static RAM whose read and write commands both carry a two-edge pipeline. The controller can issue a command on every enabled clock edge, in any mix of reads and writes, and no idle cycle is ever needed when the bus changes direction. Write data follows its address by two enabled edges. Read data leaves an output register two enabled edges after its command. Because of this, a write address must wait in a two-stage pipeline before it meets its data. A read that overtakes a pending write to the same word receives that write's bytes through a forwarding path.

Each cycle is one of two kinds. A load cycle (`adv` low) samples a fresh command: address, direction and the three chip selects. An advance cycle (`adv` high) continues the current burst. A small state machine tracks the burst type. Its states are `OP_NONE` (idle or deselected), `OP_READ` and `OP_WRITE`. Its transitions are:
- load-select-read, which enters `OP_READ`;
- load-select-write, which enters `OP_WRITE`;
- load-deselect, which enters `OP_NONE`;
- advance, which keeps the state and steps a 2-bit beat counter;
- stall, which holds everything.

The bidirectional data bus is split into `din`, `dout` and `dout_oe`.

Top module: `zt_sram`

## Requirements
- R1: After reset, `dout_oe` is 0, `dout` is 0, and no read or write is pending.
- R2: A selected read sampled at enabled edge E drives `dout` with the word and raises `dout_oe` after enabled edge E+2 (with `oe_n` low).
- R3: A selected write sampled at enabled edge E takes `din` at enabled edge E+2. It updates only the byte lanes whose `lane_we_n` bit is 0. Lane k is `din[9k+8:9k]`. The other lanes keep their contents.
- R4: Reads and writes may alternate on consecutive enabled edges with no wait cycle, and every read returns correct data.
- R5: A read issued while a write to the same address is still pending returns the pending write's bytes for its enabled lanes. It returns the array's bytes for the other lanes.
- R6: A load cycle is selected only when `ce0_n`=0, `ce1`=1 and `ce2_n`=0. In any other load cycle nothing is written, and `dout_oe` stays 0 in that command's slot.
- R7: In the output slot of a write or of an idle command, `dout_oe` is 0. Whenever `oe_n` is 1, `dout_oe` is 0 at once.
- R8: An advance cycle repeats the direction of the last load and ignores `write_n` and the chip selects. With `xor_order`=0 it uses low address bits (base+n) mod 4 for beat n, wrapping within four words. The upper address bits are unchanged. Lane enables are sampled fresh on every beat.
- R9: With `xor_order`=1, beat n of a burst uses low address bits base XOR n.
- R10: While `cke_n` is 1, no internal state or output register changes, and inputs are ignored. Pending operations resume on the next enabled edge.
- R11: An advance cycle that follows a deselected load performs no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling on rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke_n | input | 1 | Active-low clock enable; 1 stalls the block |
| ce0_n | input | 1 | Chip select, active low |
| ce1 | input | 1 | Chip select, active high |
| ce2_n | input | 1 | Chip select, active low |
| adv | input | 1 | 1 = burst advance, 0 = load a new command |
| write_n | input | 1 | 0 = write, 1 = read (load cycles only) |
| lane_we_n | input | LANES | Per-lane active-low write enables |
| xor_order | input | 1 | Burst order: 0 linear, 1 interleaved |
| addr | input | ADDR_W | Word address |
| oe_n | input | 1 | Asynchronous active-low output enable |
| din | input | LANES*LANE_W | Write data |
| dout | output | LANES*LANE_W | Registered read data |
| dout_oe | output | 1 | Output driver enable for `dout` |

## Verification
A corrupted write-address pipeline shows up as a wrong word in the output slot of a later read of that address. The fault is visible two enabled edges after that read, or as a lane changed by a neighbouring write. A stale or mismatched forwarding register shows in the merged lanes of a read that directly follows a write to the same word. A wrong beat counter or burst state gives data from the wrong word at beat n+2, or a missing or extra `dout_oe` pulse. A stall that leaks shows as `dout` moving during the stalled edges.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    function automatic logic [1:0] beat_low(input logic [1:0] base,
                                            input logic [1:0] beat,
                                            input logic       xor_mode);
        return xor_mode ? (base ^ beat) : (base + beat);
    endfunction

endpackage

// File: rtl/zt_burst_seq.sv
module zt_burst_seq
    import zt_sram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_en,
    input  logic              adv,
    input  logic              sel,
    input  logic              wr,
    input  logic              xor_mode,
    input  logic [ADDR_W-1:0] addr_in,
    output op_e               cmd_op,
    output logic [ADDR_W-1:0] cmd_addr
);
    localparam int HI_W = ADDR_W - 2;

    op_e             state_q, state_d;
    logic [1:0]      base_q, base_d;
    logic [1:0]      beat_q, beat_d;
    logic [HI_W-1:0] hi_q, hi_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= OP_NONE;
            base_q  <= '0;
            beat_q  <= '0;
            hi_q    <= '0;
        end else if (step_en) begin
            state_q <= state_d;
            base_q  <= base_d;
            beat_q  <= beat_d;
            hi_q    <= hi_d;
        end
    end

    // next state: load transitions or advance
    always_comb begin
        state_d = state_q;
        base_d  = base_q;
        beat_d  = beat_q;
        hi_d    = hi_q;
        if (!adv) begin
            state_d = !sel ? OP_NONE : (wr ? OP_WRITE : OP_READ);
            base_d  = addr_in[1:0];
            hi_d    = addr_in[ADDR_W-1:2];
            beat_d  = 2'd0;
        end else begin
            unique case (state_q)
                OP_NONE:            beat_d = beat_q;
                OP_READ, OP_WRITE:  beat_d = beat_q + 2'd1;
                default:            beat_d = beat_q;
            endcase
        end
    end

    // outputs: the command this cycle presents to the pipeline
    always_comb begin
        cmd_op   = state_d;
        cmd_addr = {hi_d, beat_low(base_d, beat_d, xor_mode)};
    end

endmodule

// File: rtl/zt_write_track.sv
module zt_write_track
    import zt_sram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_en,
    input  op_e               cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [LANES-1:0]  cmd_lanes,
    output op_e               s1_op,
    output logic [ADDR_W-1:0] s1_addr,
    output op_e               s2_op,
    output logic              commit_en,
    output logic [ADDR_W-1:0] commit_addr,
    output logic [LANES-1:0]  commit_lanes,
    output logic [LANES-1:0]  fwd_lanes
);
    logic [LANES-1:0]  s1_lanes, s2_lanes;
    logic [ADDR_W-1:0] s2_addr;
    logic              fw_valid;
    logic [ADDR_W-1:0] fw_addr;
    logic [LANES-1:0]  fw_lanes;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_op    <= OP_NONE;
            s1_addr  <= '0;
            s1_lanes <= '0;
            s2_op    <= OP_NONE;
            s2_addr  <= '0;
            s2_lanes <= '0;
            fw_valid <= 1'b0;
            fw_addr  <= '0;
            fw_lanes <= '0;
        end else if (step_en) begin
            s1_op    <= cmd_op;
            s1_addr  <= cmd_addr;
            s1_lanes <= cmd_lanes;
            s2_op    <= s1_op;
            s2_addr  <= s1_addr;
            s2_lanes <= s1_lanes;
            // remember the commit of this edge for the read one stage behind
            fw_valid <= (s2_op == OP_WRITE);
            fw_addr  <= s2_addr;
            fw_lanes <= s2_lanes;
        end
    end

    always_comb begin
        commit_en    = (s2_op == OP_WRITE);
        commit_addr  = s2_addr;
        commit_lanes = s2_lanes;
        fwd_lanes    = (s2_op == OP_READ && fw_valid && fw_addr == s2_addr) ? fw_lanes : '0;
    end

    assert_commit_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && s1_op == OP_WRITE) |=> commit_en);

endmodule

// File: rtl/zt_lane_store.sv
module zt_lane_store #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    step_en,
    input  logic [LANES*LANE_W-1:0] din,
    input  logic [ADDR_W-1:0]       rd_addr,
    input  logic                    commit_en,
    input  logic [ADDR_W-1:0]       commit_addr,
    input  logic [LANES-1:0]        commit_lanes,
    input  logic [LANES-1:0]        fwd_lanes,
    input  logic                    emit_read,
    output logic [LANES*LANE_W-1:0] dout_q,
    output logic                    drive_q
);
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int DATA_W = LANES * LANE_W;

    logic [DATA_W-1:0] merged;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] bank [DEPTH];
        logic [LANE_W-1:0] raw_q;
        logic [LANE_W-1:0] late_q;

        always_ff @(posedge clk) begin
            if (step_en) begin
                if (commit_en && commit_lanes[g])
                    bank[commit_addr] <= din[g*LANE_W +: LANE_W];
                raw_q  <= bank[rd_addr];
                late_q <= din[g*LANE_W +: LANE_W];
            end
        end

        assign merged[g*LANE_W +: LANE_W] = fwd_lanes[g] ? late_q : raw_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout_q  <= '0;
            drive_q <= 1'b0;
        end else if (step_en) begin
            drive_q <= emit_read;
            if (emit_read)
                dout_q <= merged;
        end
    end

endmodule

// File: rtl/zt_sram.sv
module zt_sram
    import zt_sram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cke_n,
    input  logic                    ce0_n,
    input  logic                    ce1,
    input  logic                    ce2_n,
    input  logic                    adv,
    input  logic                    write_n,
    input  logic [LANES-1:0]        lane_we_n,
    input  logic                    xor_order,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    oe_n,
    input  logic [LANES*LANE_W-1:0] din,
    output logic [LANES*LANE_W-1:0] dout,
    output logic                    dout_oe
);
    logic              step_en;
    logic              chip_sel;
    op_e               cmd_op;
    logic [ADDR_W-1:0] cmd_addr;
    op_e               s1_op, s2_op;
    logic [ADDR_W-1:0] s1_addr;
    logic              commit_en;
    logic [ADDR_W-1:0] commit_addr;
    logic [LANES-1:0]  commit_lanes;
    logic [LANES-1:0]  fwd_lanes;
    logic              drive_q;

    assign step_en  = !cke_n;
    assign chip_sel = !ce0_n && ce1 && !ce2_n;

    zt_burst_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_en  (step_en),
        .adv      (adv),
        .sel      (chip_sel),
        .wr       (!write_n),
        .xor_mode (xor_order),
        .addr_in  (addr),
        .cmd_op   (cmd_op),
        .cmd_addr (cmd_addr)
    );

    zt_write_track #(.ADDR_W(ADDR_W), .LANES(LANES)) u_track (
        .clk          (clk),
        .rst_n        (rst_n),
        .step_en      (step_en),
        .cmd_op       (cmd_op),
        .cmd_addr     (cmd_addr),
        .cmd_lanes    (~lane_we_n),
        .s1_op        (s1_op),
        .s1_addr      (s1_addr),
        .s2_op        (s2_op),
        .commit_en    (commit_en),
        .commit_addr  (commit_addr),
        .commit_lanes (commit_lanes),
        .fwd_lanes    (fwd_lanes)
    );

    zt_lane_store #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_store (
        .clk          (clk),
        .rst_n        (rst_n),
        .step_en      (step_en),
        .din          (din),
        .rd_addr      (s1_addr),
        .commit_en    (commit_en),
        .commit_addr  (commit_addr),
        .commit_lanes (commit_lanes),
        .fwd_lanes    (fwd_lanes),
        .emit_read    (s2_op == OP_READ),
        .dout_q       (dout),
        .drive_q      (drive_q)
    );

    assign dout_oe = drive_q && !oe_n;

    assert_oe_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !dout_oe);

    assert_write_no_drive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && s2_op != OP_READ) |=> !drive_q);

    assert_read_drive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && s2_op == OP_READ) |=> drive_q);

    assert_deselect_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !adv && !chip_sel) |=> (s1_op == OP_NONE));

    assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cke_n |=> ($stable(dout) && $stable(drive_q)));

endmodule

// File: tb/zt_sram_test.sv
module zt_sram_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cke_n = 1'b0;
    logic        ce0_n = 1'b1, ce1 = 1'b0, ce2_n = 1'b1;
    logic        adv = 1'b0, write_n = 1'b1;
    logic [3:0]  lane_we_n = 4'hF;
    logic        xor_order = 1'b0;
    logic [5:0]  addr = '0;
    logic        oe_n = 1'b0;
    logic [35:0] din = '0;
    logic [35:0] dout;
    logic        dout_oe;

    int checks = 0, failures = 0;
    int edge_cnt = 0;
    bit finished = 0;

    int          due_q[$];
    logic [35:0] dat_q[$];
    bit          drv_q[$];
    string       tag_q[$];
    logic [35:0] din_sched [int];
    logic [35:0] mem_m [64];

    int         m_op = 0;      // 0 none, 1 read, 2 write
    logic [1:0] m_base = '0, m_beat = '0;
    logic [3:0] m_hi = '0;

    zt_sram uut (
        .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .ce0_n(ce0_n), .ce1(ce1), .ce2_n(ce2_n),
        .adv(adv), .write_n(write_n), .lane_we_n(lane_we_n), .xor_order(xor_order),
        .addr(addr), .oe_n(oe_n), .din(din), .dout(dout), .dout_oe(dout_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) if (rst_n && !cke_n) edge_cnt <= edge_cnt + 1;

    task automatic check(input bit ok, input string tag, input logic [36:0] act, input logic [36:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [35:0] mk(input int s);
        return {9'(s * 3 + 1), 9'(s * 5 + 2), 9'(s * 7 + 3), 9'(s + 200)};
    endfunction

    // driver: one enabled cycle, reference model, expected item pushed
    task automatic issue(input bit a_adv, input bit a_wr, input logic [5:0] a_addr,
                         input logic [3:0] a_lanes_n, input logic [2:0] a_ces,
                         input bit a_xor, input bit a_oe_n, input logic [35:0] a_data,
                         input string a_tag);
        logic [1:0] lo;
        logic [5:0] ea;
        @(negedge clk);
        cke_n = 0; adv = a_adv; write_n = !a_wr; addr = a_addr; lane_we_n = a_lanes_n;
        {ce0_n, ce1, ce2_n} = a_ces; xor_order = a_xor; oe_n = a_oe_n;
        din = din_sched.exists(edge_cnt + 1) ? din_sched[edge_cnt + 1] : 36'h0;
        if (!a_adv) begin
            m_op = (a_ces != 3'b010) ? 0 : (a_wr ? 2 : 1);
            m_base = a_addr[1:0]; m_hi = a_addr[5:2]; m_beat = 2'd0;
        end else begin
            m_beat = m_beat + 2'd1;
        end
        lo = a_xor ? (m_base ^ m_beat) : (m_base + m_beat);
        ea = {m_hi, lo};
        due_q.push_back(edge_cnt + 3);
        tag_q.push_back(a_tag);
        if (m_op == 2) begin
            for (int l = 0; l < 4; l++)
                if (!a_lanes_n[l]) mem_m[ea][l*9 +: 9] = a_data[l*9 +: 9];
            din_sched[edge_cnt + 3] = a_data;
            dat_q.push_back(36'h0); drv_q.push_back(1'b0);
        end else if (m_op == 1) begin
            dat_q.push_back(mem_m[ea]); drv_q.push_back(1'b1);
        end else begin
            dat_q.push_back(36'h0); drv_q.push_back(1'b0);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [35:0] d, input logic [3:0] ln, input string t);
        issue(0, 1, a, ln, 3'b010, 0, 0, d, t);
    endtask
    task automatic rd(input logic [5:0] a, input string t);
        issue(0, 0, a, 4'hF, 3'b010, 0, 0, 36'h0, t);
    endtask
    task automatic nop(input string t);
        issue(0, 0, 6'd0, 4'hF, 3'b110, 0, 0, 36'h0, t);
    endtask

    task automatic stall(input int n);
        logic [35:0] hd;
        logic        he;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            hd = dout; he = dout_oe;
            cke_n = 1; adv = 0; write_n = 0; addr = 6'd9; lane_we_n = 4'h0;
            {ce0_n, ce1, ce2_n} = 3'b010;
            din = 36'hF_FFFF_FFFF;
            @(posedge clk); #(CLK_PERIOD/4);
            check(dout === hd && dout_oe === he, "R10 stall hold", {he, hd}, {dout_oe, dout});
        end
    endtask

    // monitor: scoreboard pop and compare
    always begin
        @(posedge clk); #(CLK_PERIOD/4);
        while (rst_n && due_q.size() > 0 && due_q[0] <= edge_cnt) begin
            logic [35:0] ed;
            bit          ev;
            string       et;
            bit          exp_on;
            void'(due_q.pop_front());
            ed = dat_q.pop_front(); ev = drv_q.pop_front(); et = tag_q.pop_front();
            exp_on = ev && !oe_n;
            check(dout_oe === exp_on && (!exp_on || dout === ed), et,
                  {dout_oe, dout}, {exp_on, ed});
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            checks++; failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(posedge clk); #(CLK_PERIOD/4);
        check(dout_oe === 1'b0 && dout === 36'h0, "R1 reset outputs", {dout_oe, dout}, 37'h0);
        @(posedge clk); #(CLK_PERIOD/4);
        check(dout_oe === 1'b0, "R1 nothing pending", {36'h0, dout_oe}, 37'h0);

        // fill (R3), data-slot tristate (R7)
        for (int a = 0; a < 12; a++) wr(6'(a), mk(a), 4'h0, "R7 write slot");
        // alternate writes and reads back to back (R4)
        for (int a = 0; a < 8; a++) begin
            wr(6'(16 + a), mk(40 + a), 4'h0, "R7 write slot");
            rd(6'(a), "R4 alternating read");
        end
        for (int a = 0; a < 4; a++) rd(6'(16 + a), "R4 read after alternation");
        // partial lane write (R3)
        wr(6'd2, 36'h1_2345_6789, 4'b1010, "R3 partial write");
        nop("R7 idle slot"); nop("R7 idle slot");
        rd(6'd2, "R3 lane merge");
        // coherency with pending writes (R5)
        wr(6'd3, mk(77), 4'h0, "R5 write");
        rd(6'd3, "R5 forward full word");
        wr(6'd4, mk(88), 4'b0101, "R5 write");
        rd(6'd4, "R5 forward partial lanes");
        wr(6'd5, mk(99), 4'b0011, "R5 write");
        nop("R7 idle slot");
        rd(6'd5, "R5 read two behind");
        rd(6'd5, "R5 repeat read");
        // deselects (R6)
        issue(0, 1, 6'd1, 4'h0, 3'b110, 0, 0, 36'hA_AAAA_AAAA, "R6 ce0_n high");
        issue(0, 1, 6'd1, 4'h0, 3'b000, 0, 0, 36'hB_BBBB_BBBB, "R6 ce1 low");
        issue(0, 1, 6'd1, 4'h0, 3'b011, 0, 0, 36'hC_CCCC_CCCC, "R6 ce2_n high");
        rd(6'd1, "R6 word unchanged");
        // linear write burst base 6 -> 6,7,4,5 (R8)
        wr(6'd6, mk(120), 4'h0, "R8 burst write");
        issue(1, 0, 6'd33, 4'h0, 3'b000, 0, 0, mk(121), "R8 burst write beat");
        issue(1, 0, 6'd33, 4'b1100, 3'b000, 0, 0, mk(122), "R8 burst write beat");
        issue(1, 0, 6'd33, 4'h0, 3'b000, 0, 0, mk(123), "R8 burst write beat");
        rd(6'd4, "R8 burst read");
        issue(1, 1, 6'd40, 4'h0, 3'b110, 0, 0, 36'h0, "R8 beat keeps read");
        issue(1, 1, 6'd40, 4'h0, 3'b110, 0, 0, 36'h0, "R8 beat");
        issue(1, 1, 6'd40, 4'h0, 3'b110, 0, 0, 36'h0, "R8 beat");
        rd(6'd7, "R8 wrap start");
        issue(1, 0, 6'd0, 4'hF, 3'b010, 0, 0, 36'h0, "R8 wrap beat");
        issue(1, 0, 6'd0, 4'hF, 3'b010, 0, 0, 36'h0, "R8 wrap beat");
        // interleaved read burst base 6 -> 6,7,4,5 ; base 9 -> 9,8,11,10 (R9)
        issue(0, 0, 6'd6, 4'hF, 3'b010, 1, 0, 36'h0, "R9 xor start");
        for (int i = 0; i < 3; i++) issue(1, 0, 6'd0, 4'hF, 3'b010, 1, 0, 36'h0, "R9 xor beat");
        issue(0, 0, 6'd9, 4'hF, 3'b010, 1, 0, 36'h0, "R9 xor start");
        for (int i = 0; i < 3; i++) issue(1, 0, 6'd0, 4'hF, 3'b010, 1, 0, 36'h0, "R9 xor beat");
        // stall (R10)
        rd(6'd0, "R10 read across stall");
        wr(6'd10, mk(150), 4'h0, "R10 write across stall");
        stall(3);
        nop("R10 idle"); nop("R10 idle");
        rd(6'd10, "R10 write completed after stall");
        rd(6'd9, "R10 stalled inputs ignored");
        // advance after deselect (R11)
        nop("R11 deselect load");
        issue(1, 1, 6'd11, 4'h0, 3'b010, 0, 0, 36'hD_DDDD_DDDD, "R11 no access");
        issue(1, 1, 6'd11, 4'h0, 3'b010, 0, 0, 36'hE_EEEE_EEEE, "R11 no access");
        nop("R11 idle"); nop("R11 idle");
        rd(6'd11, "R11 word unchanged");
        rd(6'd8, "R11 neighbour unchanged");
        // output enable gate (R7)
        rd(6'd0, "R7 oe_n gates read");
        nop("R7 idle");
        issue(0, 0, 6'd0, 4'hF, 3'b110, 0, 1, 36'h0, "R7 idle with oe_n");
        #(CLK_PERIOD/2);
        check(dout_oe === 1'b0, "R7 oe_n high", {36'h0, dout_oe}, 37'h0);
        for (int i = 0; i < 4; i++) nop("R7 drain");
        for (int i = 0; i < 20 && due_q.size() > 0; i++) @(posedge clk);
        @(posedge clk); #(CLK_PERIOD/4);
        check(due_q.size() == 0, "R2 scoreboard drained", 37'(due_q.size()), 37'h0);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule